// File: doc/BRIEF.md
# Descriptor-Ring Network Controller Core

This block is the host-facing core of a simple Ethernet controller. Software reaches four 16-bit control and status registers through two ports: an address port holding a register pointer and a data port that reads or writes whichever register the pointer selects. Registers 1 and 2 together form a 32-bit pointer to an initialization block in memory. That block holds a receive descriptor ring, a transmit descriptor ring and one data buffer per descriptor.

A descriptor engine works through a byte-wide memory port. Each register write requests a transmit scan. The scan sends every descriptor that is ready, as a byte stream, and hands its ownership back. When a frame is waiting on the receive stream, the engine finds the first free receive descriptor, stores the frame in that descriptor's buffer, writes the length back and hands the descriptor to software. Completion sets status bits, and an interrupt output follows them.

With the default parameters (16-entry rings, 8-byte descriptors, 256-byte buffers) memory is laid out as offsets from the pointer B = {reg2, reg1}:

- Receive descriptor i is at B + 8i.
- Transmit descriptor i is at B + 0x80 + 8i.
- Receive buffer i is at B + 0x100 + 256i.
- Transmit buffer i is at B + 0x1100 + 256i.

In a descriptor, byte 0 is the status byte and bytes 2 (high) and 3 (low) hold the length, big-endian.

Top module: `ringnet_ctrl`

## Requirements
- R1: A write to the address port (reg_sel=1) loads the pointer only when the value is below 4; otherwise the pointer keeps its old value. Reading the address port returns the pointer in bits 1:0 and zero above.
- R2: A write or read on the data port (reg_sel=0) goes to the register the pointer selects. Registers 1, 2 and 3 are plain 16-bit storage. Register 1 is the low half and register 2 the high half of the initialization block pointer.
- R3: After reset, register 0 reads 0x0001 (stop only), the pointer is 0, registers 1 to 3 read 0, both ring indices are 0 and irq is low.
- R4: Register 0 control bits are as follows.
  - Writing 1 to bit 0 sets stop.
  - Writing 1 to bit 1 clears stop; bit 1 always reads 0.
  - If both bit 0 and bit 1 are written as 1, stop is set.
  - Bit 6 (interrupt enable) is ordinary read/write.
- R5: While stop is set, no scan starts: there is no transmit byte, no memory write, rx_ready stays low, and a transmit request made while stopped is dropped.
- R6: A transmit descriptor is sent only when its status byte is exactly 0x82. Its length field holds the two's complement of the byte count. The bytes are streamed in order from its buffer, with tx_last on the final byte, and its status byte is then rewritten to 0x02.
- R7: A transmit scan starts at the transmit index, examines one lap of the ring, and sends every ready descriptor it meets. The transmit index then moves to one past the last descriptor sent.
- R8: A waiting receive frame goes to the first descriptor, counted from the receive index, whose status byte is exactly 0x80. The frame is stored at the start of that descriptor's buffer, the length field gets the byte count plus 4, the status becomes 0x02, and the receive index moves to one past it.
- R9: If a lap finds no free receive descriptor, nothing is written and rx_ready stays low. The frame waits and is taken once a free descriptor appears.
- R10: A completed transmit sets register 0 bits 9 and 7; a completed receive sets bits 10 and 7. Writing 1 to bits 7, 9 or 10 clears them.
- R11: irq is high exactly when register 0 bit 7 and bit 6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 selects the address port, 0 selects the data port |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Read value of the selected port |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when set, read otherwise |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as mem_addr |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a transmit frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a receive frame |
| rx_ready | output | 1 | Receive byte accepted this cycle when rx_valid is high |

## Verification
The transmit ring is loaded with descriptors that are ready, descriptors whose status byte is one bit off (0x83), and ready descriptors placed on both sides of the current index. The order of the output bytes then shows whether matching is exact and where a scan starts after a previous scan. Receive frames are offered with a non-free descriptor ahead of a free one, a near-miss status byte (0x81), no free descriptor at all, and a descriptor freed while the frame waits. These cases separate the skip rule, the index advance and the retry path. Register writes with out-of-range pointers, combined stop and start, write-1-to-clear and cleared interrupt enable show how the status bits and irq respond.

// File: rtl/ringnet_pkg.sv
// Package: shared constants and engine state type for the ring network core.
// Assumes: register 0 bit positions and descriptor status codes are fixed by software.
package ringnet_pkg;
    localparam int C0_STOP  = 0;
    localparam int C0_START = 1;
    localparam int C0_INEA  = 6;
    localparam int C0_INTR  = 7;
    localparam int C0_TINT  = 9;
    localparam int C0_RINT  = 10;

    localparam logic [7:0] ST_OWN = 8'h80;
    localparam logic [7:0] ST_POK = 8'h02;

    typedef enum logic [3:0] {
        S_IDLE, S_TX_STAT, S_TX_LHI, S_TX_LLO, S_TX_DATA, S_TX_FIN,
        S_RX_STAT, S_RX_DATA, S_RX_LHI, S_RX_LLO, S_RX_FIN
    } eng_state_t;
endpackage

// File: rtl/ringnet_csr.sv
// Module: register front end. Holds the pointer, the four registers and the
// transmit request flag, and drives the interrupt.
// Assumes: tx_done and rx_done are single-cycle pulses from the engine;
// kick_take is asserted by the engine when it consumes or drops a request.
module ringnet_csr
    import ringnet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        stop,
    output logic [31:0] base,
    output logic        kick,
    input  logic        kick_take,
    input  logic        tx_done,
    input  logic        rx_done,
    output logic        irq
);
    logic [1:0]  ptr;
    logic        stop_q, inea_q, intr_q, tint_q, rint_q, kick_q;
    logic [15:0] ib_lo, ib_hi, spare;
    logic        wr_ptr, wr_data, wr_c0;
    logic [15:0] c0_view;

    assign wr_ptr  = reg_wr && reg_sel;
    assign wr_data = reg_wr && !reg_sel;
    assign wr_c0   = wr_data && (ptr == 2'd0);

    // Pointer: accept only in-range values
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= 2'd0;
        else if (wr_ptr && (reg_wdata < 16'd4))
            ptr <= reg_wdata[1:0];
    end

    // Register 0: stop/start, enable, and write-1-to-clear status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            inea_q <= 1'b0;
            intr_q <= 1'b0;
            tint_q <= 1'b0;
            rint_q <= 1'b0;
        end else begin
            if (wr_c0) begin
                if (reg_wdata[C0_STOP])
                    stop_q <= 1'b1;
                else if (reg_wdata[C0_START])
                    stop_q <= 1'b0;
                inea_q <= reg_wdata[C0_INEA];
            end
            intr_q <= tx_done | rx_done | (intr_q & ~(wr_c0 & reg_wdata[C0_INTR]));
            tint_q <= tx_done | (tint_q & ~(wr_c0 & reg_wdata[C0_TINT]));
            rint_q <= rx_done | (rint_q & ~(wr_c0 & reg_wdata[C0_RINT]));
        end
    end

    // Registers 1..3: plain storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_lo <= '0;
            ib_hi <= '0;
            spare <= '0;
        end else if (wr_data) begin
            case (ptr)
                2'd1:    ib_lo <= reg_wdata;
                2'd2:    ib_hi <= reg_wdata;
                2'd3:    spare <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Transmit request: set by any register write, cleared when taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick_q <= 1'b0;
        else
            kick_q <= (kick_q & ~kick_take) | reg_wr;
    end

    // Read mux for both ports
    always_comb begin
        c0_view = '0;
        c0_view[C0_STOP] = stop_q;
        c0_view[C0_INEA] = inea_q;
        c0_view[C0_INTR] = intr_q;
        c0_view[C0_TINT] = tint_q;
        c0_view[C0_RINT] = rint_q;
        if (reg_sel)
            reg_rdata = {14'd0, ptr};
        else begin
            case (ptr)
                2'd0:    reg_rdata = c0_view;
                2'd1:    reg_rdata = ib_lo;
                2'd2:    reg_rdata = ib_hi;
                default: reg_rdata = spare;
            endcase
        end
    end

    assign stop = stop_q;
    assign base = {ib_hi, ib_lo};
    assign kick = kick_q;
    assign irq  = intr_q & inea_q;

    // R1
    ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr && reg_wdata >= 16'd4) |=> $stable(ptr));
    // R10
    intr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done || rx_done) |=> (intr_q && (tint_q || rint_q)));
endmodule

// File: rtl/ringnet_dma.sv
// Module: descriptor engine. Scans the transmit ring on request and the
// receive ring when a frame waits, moving bytes over a byte-wide memory port.
// Assumes: memory read data is valid in the same cycle as the address, and the
// transmit stream sink accepts a byte every cycle.
module ringnet_dma
    import ringnet_pkg::*;
#(
    parameter int RING_LOG2 = 4,
    parameter int BUF_LOG2  = 8,
    parameter int DESC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop,
    input  logic [31:0] base,
    input  logic        kick,
    output logic        kick_take,
    output logic        tx_done,
    output logic        rx_done,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready
);
    localparam int RING        = 1 << RING_LOG2;
    localparam int RX_DESC_OFF = 0;
    localparam int TX_DESC_OFF = RING << DESC_LOG2;
    localparam int RX_BUF_OFF  = 2 * (RING << DESC_LOG2);
    localparam int TX_BUF_OFF  = RX_BUF_OFF + (RING << BUF_LOG2);

    eng_state_t           state;
    logic [RING_LOG2-1:0] idx, scan_cnt, txptr, rxptr;
    logic [15:0]          boff, len;
    logic [7:0]           len_hi;
    logic [31:0]          txd_a, rxd_a, txb_a, rxb_a;
    logic [15:0]          tx_count;
    logic                 lap_end;

    assign txd_a    = base + 32'(TX_DESC_OFF) + (32'(idx) << DESC_LOG2);
    assign rxd_a    = base + 32'(RX_DESC_OFF) + (32'(idx) << DESC_LOG2);
    assign txb_a    = base + 32'(TX_BUF_OFF) + (32'(idx) << BUF_LOG2) + 32'(boff);
    assign rxb_a    = base + 32'(RX_BUF_OFF) + (32'(idx) << BUF_LOG2) + 32'(boff);
    assign tx_count = 16'(~{len_hi, mem_rdata} + 16'd1);
    assign lap_end  = (scan_cnt == {RING_LOG2{1'b1}});

    // Memory, stream and completion outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        tx_last   = 1'b0;
        rx_ready  = 1'b0;
        tx_done   = 1'b0;
        rx_done   = 1'b0;
        kick_take = (state == S_IDLE) && kick;
        case (state)
            S_TX_STAT: begin mem_req = 1'b1; mem_addr = txd_a; end
            S_TX_LHI:  begin mem_req = 1'b1; mem_addr = txd_a + 32'd2; end
            S_TX_LLO:  begin mem_req = 1'b1; mem_addr = txd_a + 32'd3; end
            S_TX_DATA: begin
                mem_req  = 1'b1;
                mem_addr = txb_a;
                tx_valid = 1'b1;
                tx_data  = mem_rdata;
                tx_last  = (boff == len - 16'd1);
            end
            S_TX_FIN: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = txd_a;
                mem_wdata = ST_POK; tx_done = 1'b1;
            end
            S_RX_STAT: begin mem_req = 1'b1; mem_addr = rxd_a; end
            S_RX_DATA: begin
                rx_ready = 1'b1;
                mem_req = rx_valid; mem_we = rx_valid;
                mem_addr = rxb_a; mem_wdata = rx_data;
            end
            S_RX_LHI: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = rxd_a + 32'd2; mem_wdata = len[15:8];
            end
            S_RX_LLO: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = rxd_a + 32'd3; mem_wdata = len[7:0];
            end
            S_RX_FIN: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = rxd_a;
                mem_wdata = ST_POK; rx_done = 1'b1;
            end
            default: ;
        endcase
    end

    // Scan sequencing, ring indices and byte counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            scan_cnt <= '0;
            txptr    <= '0;
            rxptr    <= '0;
            boff     <= '0;
            len      <= '0;
            len_hi   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (!stop && kick) begin
                        idx <= txptr; scan_cnt <= '0; state <= S_TX_STAT;
                    end else if (!stop && rx_valid) begin
                        idx <= rxptr; scan_cnt <= '0; state <= S_RX_STAT;
                    end
                end
                S_TX_STAT: begin
                    if (mem_rdata == (ST_OWN | ST_POK))
                        state <= S_TX_LHI;
                    else if (lap_end)
                        state <= S_IDLE;
                    else begin
                        idx <= idx + 1'b1; scan_cnt <= scan_cnt + 1'b1;
                    end
                end
                S_TX_LHI: begin
                    len_hi <= mem_rdata;
                    state  <= S_TX_LLO;
                end
                S_TX_LLO: begin
                    len   <= tx_count;
                    boff  <= '0;
                    state <= (tx_count == 16'd0) ? S_TX_FIN : S_TX_DATA;
                end
                S_TX_DATA: begin
                    boff <= boff + 16'd1;
                    if (boff == len - 16'd1)
                        state <= S_TX_FIN;
                end
                S_TX_FIN: begin
                    txptr <= idx + 1'b1;
                    if (lap_end)
                        state <= S_IDLE;
                    else begin
                        idx <= idx + 1'b1; scan_cnt <= scan_cnt + 1'b1;
                        state <= S_TX_STAT;
                    end
                end
                S_RX_STAT: begin
                    if (mem_rdata == ST_OWN) begin
                        boff <= '0; state <= S_RX_DATA;
                    end else if (lap_end)
                        state <= S_IDLE;
                    else begin
                        idx <= idx + 1'b1; scan_cnt <= scan_cnt + 1'b1;
                    end
                end
                S_RX_DATA: begin
                    if (rx_valid) begin
                        boff <= boff + 16'd1;
                        if (rx_last) begin
                            len   <= boff + 16'd5;
                            state <= S_RX_LHI;
                        end
                    end
                end
                S_RX_LHI: state <= S_RX_LLO;
                S_RX_LLO: state <= S_RX_FIN;
                S_RX_FIN: begin
                    rxptr <= idx + 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && stop) |=> (state == S_IDLE));
    // R7
    txptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> $stable(txptr));
    // R8
    rxptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rxptr));
endmodule

// File: rtl/ringnet_ctrl.sv
// Module: top of the ring network core; joins the register front end to the
// descriptor engine.
// Assumes: one clock domain and a synchronous active-low reset.
module ringnet_ctrl #(
    parameter int RING_LOG2 = 4,
    parameter int BUF_LOG2  = 8,
    parameter int DESC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready
);
    logic        stop, kick, kick_take, tx_done, rx_done;
    logic [31:0] base;

    ringnet_csr u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop(stop), .base(base),
        .kick(kick), .kick_take(kick_take), .tx_done(tx_done), .rx_done(rx_done),
        .irq(irq)
    );

    ringnet_dma #(
        .RING_LOG2(RING_LOG2), .BUF_LOG2(BUF_LOG2), .DESC_LOG2(DESC_LOG2)
    ) u_dma (
        .clk(clk), .rst_n(rst_n), .stop(stop), .base(base), .kick(kick),
        .kick_take(kick_take), .tx_done(tx_done), .rx_done(rx_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
    );
endmodule

// File: tb/sim_ringnet_ctrl.sv
// Bench: directed scenarios, one task each, against a byte memory model.
module sim_ringnet_ctrl;
    localparam int BASE = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        irq, mem_req, mem_we, tx_valid, tx_last, rx_ready;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;

    logic [7:0]  mem [0:16383];
    logic        bw_en = 1'b0;
    logic [13:0] bw_addr = '0;
    logic [7:0]  bw_data = '0;
    logic [7:0]  txcap [0:63];
    int          txn, txlasts;
    logic        cap_clr = 1'b0;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    ringnet_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
    );

    assign mem_rdata = mem[mem_addr[13:0]];

    // Memory model: bench pokes first, then design writes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16384; k++) mem[k] <= 8'h00;
        end else if (bw_en)
            mem[bw_addr] <= bw_data;
        else if (mem_req && mem_we)
            mem[mem_addr[13:0]] <= mem_wdata;
    end

    // Transmit stream capture
    always @(posedge clk) begin
        if (cap_clr) begin
            txn <= 0; txlasts <= 0;
        end else if (tx_valid) begin
            if (txn < 64) txcap[txn] <= tx_data;
            txn <= txn + 1;
            if (tx_last) txlasts <= txlasts + 1;
        end
    end

    function automatic int txd(int i); return BASE + 32'h80 + 8*i; endfunction
    function automatic int rxd(int i); return BASE + 8*i; endfunction
    function automatic int txb(int i); return BASE + 32'h1100 + 256*i; endfunction
    function automatic int rxb(int i); return BASE + 32'h100 + 256*i; endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        @(negedge clk); reg_sel = sel; #1 v = reg_rdata;
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk); bw_en = 1'b1; bw_addr = a[13:0]; bw_data = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    task automatic clr_cap();
        @(negedge clk); cap_clr = 1'b1;
        @(negedge clk); cap_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            rx_data = first + 8'(i); rx_valid = 1'b1; rx_last = (i == n-1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(0, v); chk(v, 16'h0001, "R3 csr0");
        rd(1, v); chk(v, 0, "R3 pointer");
        chk(irq, 0, "R3 irq");
        for (int r = 1; r < 4; r++) begin
            wr(1, 16'(r)); rd(0, v); chk(v, 0, "R3 csr1-3 zero");
        end
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(1, 3); wr(0, 16'hBEEF); rd(0, v); chk(v, 16'hBEEF, "R2 csr3");
        wr(1, 5); rd(1, v); chk(v, 3, "R1 pointer kept on 5");
        wr(1, 4); rd(1, v); chk(v, 3, "R1 pointer kept on 4");
        wr(1, 1); wr(0, 16'(BASE)); wr(1, 2); wr(0, 16'h0000);
        rd(0, v); chk(v, 0, "R2 csr2");
        wr(1, 1); rd(0, v); chk(v, 16'(BASE), "R2 csr1");
        rd(1, v); chk(v, 1, "R1 pointer read");
    endtask

    task automatic t_stop();
        poke(txd(0), 8'h82); poke(txd(0)+2, 8'hFF); poke(txd(0)+3, 8'hFB);
        for (int i = 0; i < 5; i++) poke(txb(0)+i, 8'h10 + 8'(i));
        poke(txd(1), 8'h83); poke(txd(1)+2, 8'hFF); poke(txd(1)+3, 8'hFF);
        poke(txb(1), 8'h99);
        poke(txd(3), 8'h82); poke(txd(3)+2, 8'hFF); poke(txd(3)+3, 8'hFD);
        for (int i = 0; i < 3; i++) poke(txb(3)+i, 8'h30 + 8'(i));
        poke(rxd(0), 8'h80);
        clr_cap();
        wr(1, 3); wr(0, 16'h0000);
        idle(60);
        chk(txn, 0, "R5 no tx while stopped");
        chk(mem[txd(0)], 8'h82, "R5 desc untouched");
        rx_data = 8'h55; rx_valid = 1'b1; rx_last = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (rx_ready) seen++; end
            chk(seen, 0, "R5 rx_ready low while stopped");
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(mem[rxb(0)], 0, "R5 no rx write");
        poke(rxd(0), 8'h00);
    endtask

    task automatic t_tx();
        logic [15:0] v;
        clr_cap();
        wr(1, 0); wr(0, 16'h0042);
        idle(200);
        chk(txn, 8, "R6 byte count");
        for (int i = 0; i < 5; i++) chk(txcap[i], 8'h10 + 8'(i), "R6 desc0 bytes");
        for (int i = 0; i < 3; i++) chk(txcap[5+i], 8'h30 + 8'(i), "R6 desc3 bytes");
        chk(txlasts, 2, "R6 tx_last count");
        chk(mem[txd(0)], 8'h02, "R6 desc0 status");
        chk(mem[txd(1)], 8'h83, "R6 non-exact skipped");
        chk(mem[txd(3)], 8'h02, "R6 desc3 status");
        rd(0, v); chk(v, 16'h02C0, "R10 tint intr set");
        chk(irq, 1, "R11 irq on");
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        wr(0, 16'h02C0); idle(100);
        rd(0, v); chk(v, 16'h0040, "R10 w1c clear");
        chk(irq, 0, "R11 irq off");
    endtask

    task automatic t_order();
        poke(txd(2), 8'h82); poke(txd(2)+2, 8'hFF); poke(txd(2)+3, 8'hFF);
        poke(txb(2), 8'h22);
        poke(txd(5), 8'h82); poke(txd(5)+2, 8'hFF); poke(txd(5)+3, 8'hFE);
        poke(txb(5), 8'h50); poke(txb(5)+1, 8'h51);
        clr_cap();
        wr(0, 16'h0040); idle(200);
        chk(txn, 3, "R7 bytes in lap");
        chk(txcap[0], 8'h50, "R7 starts after index 4");
        chk(txcap[1], 8'h51, "R7 second byte");
        chk(txcap[2], 8'h22, "R7 wraps to 2");
    endtask

    task automatic t_rx();
        logic [15:0] v;
        wr(0, 16'h06C0);
        rd(0, v); chk(v, 16'h0040, "R10 clear before rx");
        poke(rxd(0), 8'h00); poke(rxd(1), 8'h80);
        send_frame(6, 8'hA0); idle(10);
        for (int i = 0; i < 6; i++) chk(mem[rxb(1)+i], 8'hA0 + 8'(i), "R8 rx bytes");
        chk(mem[rxd(1)+2], 8'h00, "R8 len hi");
        chk(mem[rxd(1)+3], 8'h0A, "R8 len size+4");
        chk(mem[rxd(1)], 8'h02, "R8 status");
        chk(mem[rxb(0)], 8'h00, "R8 desc0 skipped");
        rd(0, v); chk(v, 16'h04C0, "R10 rint intr set");
        chk(irq, 1, "R11 irq on rx");
        poke(rxd(2), 8'h81); poke(rxd(5), 8'h80);
        send_frame(3, 8'hB0); idle(10);
        chk(mem[rxb(5)], 8'hB0, "R8 lands in 5");
        chk(mem[rxb(5)+2], 8'hB2, "R8 last byte");
        chk(mem[rxd(5)+3], 8'h07, "R8 len 7");
        chk(mem[rxd(2)], 8'h81, "R8 near-miss untouched");
        chk(mem[rxb(2)], 8'h00, "R8 near-miss buffer");
    endtask

    task automatic t_rx_wait();
        int seen = 0;
        rx_data = 8'hC0; rx_valid = 1'b1; rx_last = 1'b1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (rx_ready) seen++; end
        chk(seen, 0, "R9 waits without descriptor");
        chk(mem[rxd(2)], 8'h81, "R9 nothing written");
        poke(rxd(9), 8'h80);
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        idle(10);
        chk(mem[rxb(9)], 8'hC0, "R9 taken after freeing");
        chk(mem[rxd(9)+3], 8'h05, "R9 len");
    endtask

    task automatic t_irq_mask();
        logic [15:0] v;
        wr(0, 16'h0000); rd(0, v);
        chk(v, 16'h0480, "R11 intr kept, enable off");
        chk(irq, 0, "R11 masked");
        wr(0, 16'h0040); chk(irq, 1, "R11 unmasked");
    endtask

    task automatic t_stop_start();
        logic [15:0] v;
        wr(0, 16'h0003); rd(0, v); chk(v, 16'h0481, "R4 stop wins");
        wr(0, 16'h0002); rd(0, v); chk(v, 16'h0480, "R4 start clears, reads 0");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_stop();
        t_tx();
        t_w1c();
        t_order();
        t_rx();
        t_rx_wait();
        t_irq_mask();
        t_stop_start();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule